// File: doc/BRIEF.md
# Interrupt Source Routing Controller

This block sits between a set of peripheral interrupt sources and the three parties that may service them: a group of DMA channels, a data-transfer engine and the CPU interrupt line. Every source pulse is latched. Two per-source controls decide where the latched request goes.

The first control is a DMA-claim bit. A claimed source is serviced by DMA alone. The second control is a transfer-enable bit, and it applies only to unclaimed sources. An unclaimed source with the bit set goes to the transfer engine. An unclaimed source with the bit clear goes straight to the CPU.

Each DMA channel picks its own source through a 4-bit select field and sees that source's latched pulse directly. This DMA path does not depend on the claim bit, so a source can be serviced by DMA and by the CPU path side by side.

Requests bound for the transfer engine are arbitrated by fixed index order. They are issued one at a time over a valid/ready handshake. The engine then reports completion with a done pulse carrying two flags: an interrupt-select flag and a count-zero flag. If either flag is set, the block clears that source's transfer-enable bit and raises a CPU interrupt for the source. The CPU interrupt for a source therefore always follows its transfer. A CPU pending bit stays set until the CPU acknowledges that source index.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, te_en, cpu_pend, cpu_irq, act_valid and dma_req are all 0.
- R2: dma_req[c] is high one cycle after a pulse on the source whose index is in dma_sel bits [4c+3:4c]. It stays high until dma_ack[c] is applied for one cycle.
- R3: While dma_claim[i] is 1, a pulse on source i never makes act_valid high with act_idx = i, and never sets cpu_pend[i].
- R4: An unclaimed source i with te_en[i] = 0 sets cpu_pend[i] on the second clock edge after its pulse. cpu_irq is the OR of all cpu_pend bits.
- R5: An unclaimed source i with te_en[i] = 1 drives act_valid = 1 with act_idx = i one cycle after its pulse. The request is consumed when act_ready is seen. A done pulse with both flags 0 leaves te_en[i] at 1 and raises no CPU interrupt.
- R6: A done pulse with done_isel = 1 clears te_en of the active source and sets its cpu_pend on the same edge. cpu_pend is never set for a transfer-routed source before its done pulse.
- R7: A done pulse with done_cnt0 = 1 has the effect of R6 whatever done_isel is.
- R8: When several transfer requests are pending, the lowest source index is issued first.
- R9: From an accepted activation until the next done pulse, act_valid stays 0.
- R10: cpu_pend[i] stays set until cpu_ack is applied with cpu_ack_idx = i. An acknowledge for another index leaves it set.
- R11: An unclaimed source that a DMA channel also selects raises both dma_req and cpu_pend. Clearing one does not clear the other.
- R12: A cycle with te_wr = 1 loads te_en from te_wdata on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Peripheral interrupt pulses, one per source |
| dma_claim | input | NSRC | Per-source DMA-claim bits |
| te_wr | input | 1 | Load strobe for the transfer-enable bits |
| te_wdata | input | NSRC | Transfer-enable value to load |
| te_en | output | NSRC | Current transfer-enable bits |
| dma_sel | input | NDMA*4 | Per-channel source select, 4 bits per channel |
| dma_ack | input | NDMA | Per-channel clear of the selected request |
| dma_req | output | NDMA | Per-channel activation request |
| act_valid | output | 1 | Transfer activation offered |
| act_idx | output | 4 | Source index of the offered activation |
| act_ready | input | 1 | Transfer engine accepts the activation |
| done | input | 1 | Transfer completion pulse |
| done_isel | input | 1 | Interrupt-select flag of the completed transfer |
| done_cnt0 | input | 1 | Count-zero flag of the completed transfer |
| cpu_ack | input | 1 | CPU acknowledge strobe |
| cpu_ack_idx | input | 4 | Source index being acknowledged |
| cpu_pend | output | NSRC | Per-source CPU pending bits |
| cpu_irq | output | 1 | CPU interrupt line |

## Verification
A wrong busy flag or a wrong active index shows at the ports on the very next edge. Either a second act_valid appears during a transfer, or the done pulse clears te_en and sets cpu_pend on the wrong bit. A stale or missed request latch shows one or two cycles after the pulse, as an activation or pending bit that should or should not be there. A faulty DMA select decode shows as soon as the selected source pulses, because the channel's dma_req stays low, or fails to drop after dma_ack.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NSRC = 16,
  parameter int NDMA = 4,
  localparam int IW = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_irq,
  input  logic [NSRC-1:0]  dma_claim,
  input  logic             te_wr,
  input  logic [NSRC-1:0]  te_wdata,
  output logic [NSRC-1:0]  te_en,
  input  logic [NDMA*IW-1:0] dma_sel,
  input  logic [NDMA-1:0]  dma_ack,
  output logic [NDMA-1:0]  dma_req,
  output logic             act_valid,
  output logic [IW-1:0]    act_idx,
  input  logic             act_ready,
  input  logic             done,
  input  logic             done_isel,
  input  logic             done_cnt0,
  input  logic             cpu_ack,
  input  logic [IW-1:0]    cpu_ack_idx,
  output logic [NSRC-1:0]  cpu_pend,
  output logic             cpu_irq
);

  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  logic [NSRC-1:0] req_q, dlat_q, te_q, pend_q;
  logic [NSRC-1:0] elig, to_cpu, dclr, fin_mask, acc_mask, ack_mask;
  logic            busy_q;
  logic [IW-1:0]   cur_q, win;
  logic            accept, finish;

  assign elig   = req_q & te_q & ~dma_claim;
  assign to_cpu = req_q & ~te_q & ~dma_claim;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = IW'(i);
  end

  assign act_valid = ~busy_q & (|elig);
  assign act_idx   = win;
  assign accept    = act_valid & act_ready;
  assign finish    = busy_q & done & (done_isel | done_cnt0);

  assign acc_mask = accept ? (ONE << win) : '0;
  assign fin_mask = finish ? (ONE << cur_q) : '0;
  assign ack_mask = cpu_ack ? (ONE << cpu_ack_idx) : '0;

  always_comb begin
    dclr = '0;
    for (int c = 0; c < NDMA; c++)
      if (dma_ack[c]) dclr[dma_sel[c*IW +: IW]] = 1'b1;
  end

  for (genvar c = 0; c < NDMA; c++) begin : g_dma
    assign dma_req[c] = dlat_q[dma_sel[c*IW +: IW]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      dlat_q <= '0;
      te_q   <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      req_q  <= (req_q & ~to_cpu & ~acc_mask) | (src_irq & ~dma_claim);
      dlat_q <= (dlat_q & ~dclr) | src_irq;
      te_q   <= (te_wr ? te_wdata : te_q) & ~fin_mask;
      pend_q <= (pend_q & ~ack_mask) | to_cpu | fin_mask;
      if (accept) begin
        busy_q <= 1'b1;
        cur_q  <= win;
      end else if (busy_q && done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign te_en    = te_q;
  assign cpu_pend = pend_q;
  assign cpu_irq  = |pend_q;

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int NSRC = 16,
  localparam int IW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] dma_claim,
  input logic [NSRC-1:0] te_en,
  input logic            act_valid,
  input logic [IW-1:0]   act_idx,
  input logic            act_ready,
  input logic            done,
  input logic            done_isel,
  input logic            done_cnt0,
  input logic [NSRC-1:0] cpu_pend,
  input logic            busy_q,
  input logic [IW-1:0]   cur_q
);

  // R3
  claim_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> !dma_claim[act_idx]);

  // R5
  act_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> te_en[act_idx]);

  // R9
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_ready) |=> !act_valid);

  // R7
  fin_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done && (done_isel || done_cnt0)) |=>
      (!te_en[$past(cur_q)] && cpu_pend[$past(cur_q)]));

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // R6
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_pend[i]) && $past(te_en[i])) |-> $past(done));
    // R3
    claim_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_pend[i]) |-> (!$past(dma_claim[i]) || $past(done)));
  end

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_claim(dma_claim), .te_en(te_en),
  .act_valid(act_valid), .act_idx(act_idx), .act_ready(act_ready),
  .done(done), .done_isel(done_isel), .done_cnt0(done_cnt0),
  .cpu_pend(cpu_pend), .busy_q(busy_q), .cur_q(cur_q)
);

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NSRC = 16;
  localparam int NDMA = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_irq = '0, dma_claim = '0, te_wdata = '0;
  logic te_wr = 1'b0;
  logic [NSRC-1:0] te_en, cpu_pend;
  logic [NDMA*4-1:0] dma_sel = {4'd15, 4'd11, 4'd7, 4'd2};
  logic [NDMA-1:0] dma_ack = '0, dma_req;
  logic act_valid, act_ready = 1'b0, done = 1'b0, done_isel = 1'b0, done_cnt0 = 1'b0;
  logic [3:0] act_idx, cpu_ack_idx = '0;
  logic cpu_ack = 1'b0, cpu_irq;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_route_ctrl #(.NSRC(NSRC), .NDMA(NDMA)) u_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .dma_claim(dma_claim),
    .te_wr(te_wr), .te_wdata(te_wdata), .te_en(te_en), .dma_sel(dma_sel),
    .dma_ack(dma_ack), .dma_req(dma_req), .act_valid(act_valid),
    .act_idx(act_idx), .act_ready(act_ready), .done(done),
    .done_isel(done_isel), .done_cnt0(done_cnt0), .cpu_ack(cpu_ack),
    .cpu_ack_idx(cpu_ack_idx), .cpu_pend(cpu_pend), .cpu_irq(cpu_irq)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    src_irq = m; step(); src_irq = '0;
  endtask

  task automatic load_te(input logic [NSRC-1:0] v);
    te_wr = 1'b1; te_wdata = v; step(); te_wr = 1'b0;
  endtask

  task automatic accept_one();
    act_ready = 1'b1; step(); act_ready = 1'b0;
  endtask

  task automatic finish_one(input logic isel, input logic cnt0);
    done = 1'b1; done_isel = isel; done_cnt0 = cnt0; step();
    done = 1'b0; done_isel = 1'b0; done_cnt0 = 1'b0;
  endtask

  task automatic ack_cpu(input logic [3:0] idx);
    cpu_ack = 1'b1; cpu_ack_idx = idx; step(); cpu_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 te_en", 32'(te_en), 0);
    chk("R1 cpu_pend", 32'(cpu_pend), 0);
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    chk("R1 act_valid", 32'(act_valid), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
  endtask

  task automatic t_load();
    load_te(16'h00F0);
    chk("R12 te_en load", 32'(te_en), 32'h00F0);
    load_te(16'h0050);
    chk("R12 te_en reload", 32'(te_en), 32'h0050);
  endtask

  task automatic t_cpu_route();
    load_te(16'h0000);
    pulse(16'h0020);
    chk("R4 not yet pending", 32'(cpu_pend), 0);
    step();
    chk("R4 pending", 32'(cpu_pend), 32'h0020);
    chk("R4 cpu_irq", 32'(cpu_irq), 1);
    chk("R4 no activation", 32'(act_valid), 0);
    step(3);
    chk("R10 held", 32'(cpu_pend), 32'h0020);
    ack_cpu(4'd6);
    chk("R10 other ack", 32'(cpu_pend), 32'h0020);
    ack_cpu(4'd5);
    chk("R10 cleared", 32'(cpu_pend), 0);
    chk("R10 cpu_irq low", 32'(cpu_irq), 0);
  endtask

  task automatic t_xfer();
    load_te(16'h0050);
    pulse(16'h0010);
    chk("R5 act_valid", 32'(act_valid), 1);
    chk("R5 act_idx", 32'(act_idx), 4);
    accept_one();
    chk("R9 valid low after accept", 32'(act_valid), 0);
    pulse(16'h0040);
    chk("R9 held while busy", 32'(act_valid), 0);
    finish_one(1'b0, 1'b0);
    chk("R5 te_en kept", 32'(te_en), 32'h0050);
    chk("R5 no cpu", 32'(cpu_pend), 0);
    chk("R9 next offered", 32'(act_valid), 1);
    chk("R9 next idx", 32'(act_idx), 6);
    accept_one();
    chk("R6 not pending before done", 32'(cpu_pend), 0);
    finish_one(1'b1, 1'b0);
    chk("R6 te_en cleared", 32'(te_en), 32'h0010);
    chk("R6 pending", 32'(cpu_pend), 32'h0040);
    chk("R6 no more activations", 32'(act_valid), 0);
    ack_cpu(4'd6);
  endtask

  task automatic t_cnt0();
    load_te(16'h0030);
    pulse(16'h0020);
    chk("R7 act_idx", 32'(act_idx), 5);
    accept_one();
    finish_one(1'b0, 1'b1);
    chk("R7 te_en cleared", 32'(te_en), 32'h0010);
    chk("R7 pending", 32'(cpu_pend), 32'h0020);
    ack_cpu(4'd5);
    chk("R7 acked", 32'(cpu_pend), 0);
  endtask

  task automatic t_prio();
    load_te(16'hFFFF);
    pulse(16'h1208);
    chk("R8 first", 32'(act_idx), 3);
    accept_one(); finish_one(1'b0, 1'b0);
    chk("R8 second", 32'(act_idx), 9);
    accept_one(); finish_one(1'b0, 1'b0);
    chk("R8 third", 32'(act_idx), 12);
    accept_one(); finish_one(1'b0, 1'b0);
    chk("R8 drained", 32'(act_valid), 0);
    chk("R8 no cpu", 32'(cpu_pend), 0);
  endtask

  task automatic t_claim();
    dma_claim = 16'h0084;
    load_te(16'h0004);
    pulse(16'h0004);
    chk("R3 no activation", 32'(act_valid), 0);
    chk("R2 claimed source reaches dma", 32'(dma_req), 32'h1);
    pulse(16'h0080);
    step(2);
    chk("R3 no activation later", 32'(act_valid), 0);
    chk("R3 no cpu", 32'(cpu_pend), 0);
    chk("R2 ch1 request", 32'(dma_req), 32'h3);
    dma_ack = 4'b0010; step(); dma_ack = '0;
    chk("R2 ch1 cleared", 32'(dma_req), 32'h1);
    dma_ack = 4'b0001; step(); dma_ack = '0;
    chk("R2 ch0 cleared", 32'(dma_req), 0);
    dma_claim = '0;
    step(2);
    chk("R3 nothing left after unclaim", 32'(cpu_pend), 0);
  endtask

  task automatic t_indep();
    load_te(16'h0000);
    pulse(16'h0800);
    chk("R11 dma request", 32'(dma_req), 32'h4);
    step();
    chk("R11 cpu pending", 32'(cpu_pend), 32'h0800);
    ack_cpu(4'd11);
    chk("R11 dma kept after cpu ack", 32'(dma_req), 32'h4);
    dma_ack = 4'b0100; step(); dma_ack = '0;
    chk("R11 dma cleared", 32'(dma_req), 0);
    chk("R11 cpu stays clear", 32'(cpu_pend), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_load();
    t_cpu_route();
    t_xfer();
    t_cnt0();
    t_prio();
    t_claim();
    t_indep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule